// File: doc/BRIEF.md
# Duplicated-Execution Checkpoint and Recovery Controller

This block holds the architected register state of a processor in a checkpoint array protected by an error-correcting code. Two copies of an execution unit produce every result in parallel. A result reaches the checkpoint only when both copies return the same register index and the same data. When the copies disagree, the controller flushes all work in flight. It then streams the whole checkpoint back to the working register file, one entry per cycle, correcting single-bit errors on the way, and releases a restart at the address of the failing instruction.

A retry that clears the fault leaves no trace in the state. Some faults cannot be cured by a retry: a second disagreement at the same instruction address on the first result after a refresh, or an uncorrectable word in the checkpoint. For these the controller raises a sticky failover flag, which asks for the checkpoint to be moved to a spare processor. A fault-injection port flips chosen bits of a stored codeword, so that soft errors in the array can be modelled.

Top module: `ckpt_recovery`

## Requirements
- R1: While `commit_ready` is high, a cycle with `res_valid` high in which `a_idx`/`a_data` equal `b_idx`/`b_data` raises `commit_ok` in that same cycle. The checkpoint entry at that index then holds the data, which any later refresh shows.
- R2: A `res_valid` cycle accepted while `commit_ready` is high, in which the index or the data differ, raises `flush` in that same cycle. It does not raise `commit_ok` and leaves the checkpoint unchanged.
- R3: After an ordinary flush, `rf_valid` is high from the next cycle for exactly NREG cycles, with `rf_idx` counting 0 to NREG-1 and `rf_data` carrying the checkpoint contents.
- R4: Each checkpoint word is kept as a 39-bit SECDED codeword. A single flipped bit anywhere in a codeword, check bits included, is corrected in `rf_data`.
- R5: A codeword with two flipped bits makes `rf_valid` low for that entry. `failover` rises on the next cycle, and the refresh stops with no restart.
- R6: `rf_done` is high for one cycle, in the cycle after the last refresh entry. `restart_valid` is high for one cycle after that, with `restart_pc` equal to the `res_pc` of the failing result. `commit_ready` returns high in the cycle after that.
- R7: From a flush until the controller returns to normal operation, `commit_ready` is low and results are ignored: `commit_ok` and `flush` stay low and the checkpoint is not written.
- R8: A disagreement on the first result after a refresh, at the same `res_pc` as the fault that caused that refresh, is persistent. It raises `flush`, and `failover` the next cycle, with no refresh. A successful commit in between, or a different `res_pc`, gives an ordinary retry instead.
- R9: `failover` stays high until reset, and `commit_ready` stays low while it is set.
- R10: After reset, `commit_ready` is high, all other outputs are low, and every checkpoint entry holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| res_valid | input | 1 | Both unit results are present |
| res_pc | input | PCW | Instruction address of the result |
| a_idx | input | IW | Register index from unit A |
| a_data | input | 32 | Result data from unit A |
| b_idx | input | IW | Register index from unit B |
| b_data | input | 32 | Result data from unit B |
| flip_en | input | 1 | Fault injection enable |
| flip_idx | input | IW | Checkpoint entry to corrupt |
| flip_mask | input | 39 | Codeword bits to invert |
| commit_ready | output | 1 | Results are being accepted |
| commit_ok | output | 1 | Result agreed and was committed |
| flush | output | 1 | Discard all in-flight work |
| rf_valid | output | 1 | Refresh entry valid |
| rf_idx | output | IW | Refresh entry index |
| rf_data | output | 32 | Corrected refresh data |
| rf_done | output | 1 | Refresh finished pulse |
| restart_valid | output | 1 | Restart release pulse |
| restart_pc | output | PCW | Address to resume from |
| failover | output | 1 | Persistent or uncorrectable fault |

## Verification
On every cycle, the assertions check the following. No commit coincides with a flush or with a refresh beat. A flush is followed by a refresh or by failover. The done pulse follows the last refresh entry, and the restart follows the done pulse. Failover never clears. The bench scenarios are the only way to show that the refresh stream carries the right data. They also show that ECC correction and the double-error stop work, that the persistence rule tells a repeat at the same address apart from a different address or an intervening commit, and that results offered during recovery are really dropped.

// File: rtl/ckpt_recovery.sv
module ckpt_recovery #(
  parameter int NREG = 8,
  parameter int PCW  = 32,
  localparam int IW  = $clog2(NREG),
  localparam int DW  = 32,
  localparam int CW  = 39
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           res_valid,
  input  logic [PCW-1:0] res_pc,
  input  logic [IW-1:0]  a_idx,
  input  logic [DW-1:0]  a_data,
  input  logic [IW-1:0]  b_idx,
  input  logic [DW-1:0]  b_data,
  input  logic           flip_en,
  input  logic [IW-1:0]  flip_idx,
  input  logic [CW-1:0]  flip_mask,
  output logic           commit_ready,
  output logic           commit_ok,
  output logic           flush,
  output logic           rf_valid,
  output logic [IW-1:0]  rf_idx,
  output logic [DW-1:0]  rf_data,
  output logic           rf_done,
  output logic           restart_valid,
  output logic [PCW-1:0] restart_pc,
  output logic           failover
);

  typedef enum logic [2:0] {S_RUN, S_REF, S_DONE, S_RST, S_HALT} st_t;

  function automatic logic [CW-1:0] enc(input logic [DW-1:0] d);
    logic [CW-1:0] c;
    int k;
    c = '0;
    k = 0;
    for (int p = 1; p < CW; p++)
      if ((p & (p - 1)) != 0) begin
        c[p] = d[k];
        k++;
      end
    for (int j = 0; j < 6; j++)
      for (int p = 1; p < CW; p++)
        if (((p >> j) & 1) == 1 && p != (1 << j)) c[1 << j] ^= c[p];
    c[0] = ^c[CW-1:1];
    return c;
  endfunction

  function automatic logic [DW:0] dec(input logic [CW-1:0] cin);
    logic [CW-1:0] c;
    logic [5:0] syn;
    logic par, bad;
    logic [DW-1:0] d;
    int k;
    c = cin;
    syn = '0;
    for (int p = 1; p < CW; p++)
      if (c[p]) syn ^= 6'(p);
    par = ^c;
    bad = 1'b0;
    if (syn != 0) begin
      if (!par || syn >= 6'(CW)) bad = 1'b1;
      else c[syn] = ~c[syn];
    end
    k = 0;
    d = '0;
    for (int p = 1; p < CW; p++)
      if ((p & (p - 1)) != 0) begin
        d[k] = c[p];
        k++;
      end
    return {bad, d};
  endfunction

  st_t            state;
  logic [IW-1:0]  ptr;
  logic           retried;
  logic [PCW-1:0] retry_pc;
  logic           fail_q;
  logic [CW-1:0]  ckpt [NREG];
  logic           dbl;
  logic [DW-1:0]  cor;

  wire agree   = (a_idx == b_idx) && (a_data == b_data);
  wire accept  = res_valid && (state == S_RUN);
  wire persist = retried && (res_pc == retry_pc);

  assign {dbl, cor}    = dec(ckpt[ptr]);
  assign commit_ready  = (state == S_RUN);
  assign commit_ok     = accept && agree;
  assign flush         = accept && !agree;
  assign rf_valid      = (state == S_REF) && !dbl;
  assign rf_idx        = ptr;
  assign rf_data       = cor;
  assign rf_done       = (state == S_DONE);
  assign restart_valid = (state == S_RST);
  assign restart_pc    = retry_pc;
  assign failover      = fail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_RUN;
      ptr      <= '0;
      retried  <= 1'b0;
      retry_pc <= '0;
      fail_q   <= 1'b0;
      for (int i = 0; i < NREG; i++) ckpt[i] <= enc('0);
    end else begin
      case (state)
        S_RUN: begin
          if (commit_ok) begin
            ckpt[a_idx] <= enc(a_data);
            retried     <= 1'b0;
          end
          if (flush) begin
            if (persist) begin
              fail_q <= 1'b1;
              state  <= S_HALT;
            end else begin
              retried  <= 1'b1;
              retry_pc <= res_pc;
              ptr      <= '0;
              state    <= S_REF;
            end
          end
        end
        S_REF: begin
          if (dbl) begin
            fail_q <= 1'b1;
            state  <= S_HALT;
          end else if (ptr == IW'(NREG - 1)) state <= S_DONE;
          else ptr <= ptr + 1'b1;
        end
        S_DONE:  state <= S_RST;
        S_RST:   state <= S_RUN;
        default: state <= S_HALT;
      endcase
      if (flip_en) ckpt[flip_idx] <= ckpt[flip_idx] ^ flip_mask;
    end
  end

  p_no_commit_on_flush_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !commit_ok);
  p_no_commit_in_refresh_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_valid || rf_done || restart_valid) |-> !commit_ok);
  p_flush_then_recover_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (rf_valid || failover));
  p_done_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rf_done |-> $past(rf_valid && rf_idx == IW'(NREG - 1)));
  p_restart_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restart_valid |-> $past(rf_done));
  p_failover_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    failover |=> (failover && !commit_ready));

endmodule

// File: tb/test_ckpt_recovery.sv
module test_ckpt_recovery;
  localparam int N = 8;
  localparam int IW = 3;

  logic clk = 0, rst_n = 0;
  logic res_valid = 0;
  logic [31:0] res_pc = 0, a_data = 0, b_data = 0;
  logic [IW-1:0] a_idx = 0, b_idx = 0, flip_idx = 0;
  logic flip_en = 0;
  logic [38:0] flip_mask = 0;
  logic commit_ready, commit_ok, flush, rf_valid, rf_done, restart_valid, failover;
  logic [IW-1:0] rf_idx;
  logic [31:0] rf_data, restart_pc;

  int checks = 0, errors = 0;
  logic [31:0] model [N];

  always #2 clk = ~clk;

  ckpt_recovery #(.NREG(N), .PCW(32)) i_ckpt_recovery (
    .clk, .rst_n, .res_valid, .res_pc, .a_idx, .a_data, .b_idx, .b_data,
    .flip_en, .flip_idx, .flip_mask, .commit_ready, .commit_ok, .flush,
    .rf_valid, .rf_idx, .rf_data, .rf_done, .restart_valid, .restart_pc, .failover);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; res_valid = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < N; i++) model[i] = 0;
    #1;
    chk("R10 ready", commit_ready, 1);
    chk("R10 flush", flush, 0);
    chk("R10 rf_valid", rf_valid, 0);
    chk("R10 failover", failover, 0);
    chk("R10 restart", restart_valid, 0);
  endtask

  task automatic send(int ia, logic [31:0] da, int ib, logic [31:0] db,
                      logic [31:0] pc, bit exp_ok, string req);
    @(negedge clk);
    res_valid = 1; a_idx = IW'(ia); b_idx = IW'(ib);
    a_data = da; b_data = db; res_pc = pc;
    #1;
    chk({req, " commit_ok"}, commit_ok, exp_ok);
    chk({req, " flush"}, flush, !exp_ok);
    if (exp_ok) model[ia] = da;
    @(negedge clk); res_valid = 0;
  endtask

  task automatic collect(logic [31:0] pc, bit junk);
    for (int i = 0; i < N; i++) begin
      if (i > 0) @(negedge clk);
      #1;
      chk("R3 rf_valid", rf_valid, 1);
      chk("R3 rf_idx", rf_idx, i);
      chk("R3 rf_data", rf_data, model[i]);
      chk("R7 ready low", commit_ready, 0);
      if (junk) begin
        chk("R7 no commit", commit_ok, 0);
        chk("R7 no flush", flush, 0);
        res_valid = 1; a_idx = 1; b_idx = 1; a_data = 32'hdead; b_data = 32'hdead;
      end
    end
    @(negedge clk); #1;
    chk("R6 rf_done", rf_done, 1);
    chk("R6 rf_valid off", rf_valid, 0);
    @(negedge clk); #1;
    chk("R6 restart", restart_valid, 1);
    chk("R6 restart_pc", restart_pc, pc);
    chk("R7 no commit restart", commit_ok, 0);
    res_valid = 0;
    @(negedge clk); #1;
    chk("R6 ready back", commit_ready, 1);
    chk("R6 restart off", restart_valid, 0);
  endtask

  task automatic inject(int idx, logic [38:0] m);
    @(negedge clk); flip_en = 1; flip_idx = IW'(idx); flip_mask = m;
    @(negedge clk); flip_en = 0;
  endtask

  task automatic t_commit();
    for (int i = 0; i < N; i++) send(i, 32'h1000_0001 * (i + 3), i, 32'h1000_0001 * (i + 3), 32'h10 + i, 1, "R1");
  endtask

  task automatic t_data_mismatch();
    send(3, 32'haaaa, 3, 32'haaab, 32'h100, 0, "R2");
    collect(32'h100, 1);
  endtask

  task automatic t_idx_mismatch_after_commit();
    send(0, 32'h5555, 0, 32'h5555, 32'h104, 1, "R1 clear");
    send(2, 32'h77, 4, 32'h77, 32'h100, 0, "R8 commit between");
    chk("R8 no failover", failover, 0);
    collect(32'h100, 0);
  endtask

  task automatic t_diff_pc();
    send(5, 1, 5, 2, 32'h200, 0, "R8 other pc");
    chk("R8 no failover pc", failover, 0);
    collect(32'h200, 0);
  endtask

  task automatic t_single_bit();
    send(6, 32'h99, 6, 32'h99, 32'h204, 1, "R1 clear2");
    inject(2, 39'h1 << 7);
    inject(6, 39'h1 << 36);
    inject(4, 39'h1);
    inject(7, 39'h1 << 32);
    send(1, 3, 1, 4, 32'h300, 0, "R4 trigger");
    collect(32'h300, 0);
  endtask

  task automatic t_persist();
    send(1, 3, 1, 4, 32'h300, 0, "R8 persist");
    #1;
    chk("R8 failover", failover, 1);
    chk("R8 no refresh", rf_valid, 0);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      res_valid = 1; a_idx = 0; b_idx = 0; a_data = 9; b_data = 9; #1;
      chk("R9 sticky", failover, 1);
      chk("R9 ready low", commit_ready, 0);
      chk("R9 no commit", commit_ok, 0);
      chk("R9 no restart", restart_valid, 0);
    end
    res_valid = 0;
  endtask

  task automatic t_reset_zero();
    send(0, 1, 0, 2, 32'h40, 0, "R10 trigger");
    collect(32'h40, 0);
  endtask

  task automatic t_double();
    send(5, 32'hcafe, 5, 32'hcafe, 32'h44, 1, "R1 c5");
    inject(5, (39'h1 << 3) | (39'h1 << 20));
    send(2, 1, 2, 0, 32'h400, 0, "R5 trigger");
    for (int i = 0; i < 5; i++) begin
      if (i > 0) @(negedge clk);
      #1;
      chk("R5 good entry", rf_data, model[i]);
      chk("R5 good valid", rf_valid, 1);
    end
    @(negedge clk); #1;
    chk("R5 bad entry hidden", rf_valid, 0);
    chk("R5 not yet failover", failover, 0);
    @(negedge clk); #1;
    chk("R5 failover", failover, 1);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); #1;
      chk("R5 no restart", restart_valid, 0);
      chk("R5 no done", rf_done, 0);
    end
  endtask

  initial begin
    #(4 * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    t_commit();
    t_data_mismatch();
    t_idx_mismatch_after_commit();
    t_diff_pc();
    t_single_bit();
    t_persist();
    do_reset();
    t_reset_zero();
    t_double();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule